// File: doc/BRIEF.md
# Supply Warning Status and Trip Select Register

This block is an 8-bit memory-mapped register that sits between a supply-voltage monitor and the processor bus. An external comparator gives a digital "supply is below the warning threshold" level. The register turns that level into a sticky warning flag that software reads and acknowledges. It also stores two trip-point select bits and drives them to the analog detector: one picks the warning threshold and one picks the detect threshold.

Two reset inputs with different retention rules are provided. Power-on reset clears every stored bit. The other reset input stands for low-voltage resets and all other resets. It clears the flag and the input synchronizer, and the two threshold selects keep their values. The bus port is a plain single-cycle access: a read returns data combinationally in the cycle it is addressed, and a write takes effect at the next clock edge. There is no wait state and no back-pressure, so no valid/ready handshake is used.

Bit layout as seen by software: bit 7 warning flag (read only), bit 6 acknowledge strobe (write only, reads 0), bit 5 detect-threshold select, bit 4 warning-threshold select, bits 3..0 reserved and always 0.

Top module: `lvw_status_reg`

## Requirements
- R1: When power-on reset (`por_n` low) is released, the flag and both select outputs are 0, and a read of the register returns 0x00.
- R2: A pulse on the general reset (`sys_rst_n` low) clears the flag (bit 7) and leaves bit 5 and bit 4 and the `detect_sel_o` / `warn_sel_o` outputs unchanged.
- R3: `below_warn_i` passes through a two-flop synchronizer. When it is raised, bit 7 reads 0 after two rising edges and 1 after the third. The flag then stays 1 after the input falls.
- R4: A write with bit 6 set clears the flag when the synchronized warning is low in that cycle.
- R5: If the synchronized warning is high in the cycle of an acknowledge write, the set wins and the flag stays 1. This includes the two cycles after the raw input falls.
- R6: A write to the register address loads bit 5 into `detect_sel_o` and bit 4 into `warn_sel_o` (0 selects the low threshold, 1 the high threshold). Both bits read back at the same positions.
- R7: Writes to bit 7 and to bits 3..0 have no effect. Bit 6 and bits 3..0 always read 0.
- R8: Accesses whose `reg_addr` is not `REG_ADDR` change nothing. `reg_rdata` is 0x00 whenever the cycle is not a read of `REG_ADDR`.
- R9: If the input is already below the threshold when either reset is released, the flag reads 1 after the third rising edge following release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | Low-voltage and general reset, active low, asynchronous |
| below_warn_i | input | 1 | Asynchronous comparator level, 1 = supply below warning threshold |
| reg_en | input | 1 | Bus access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Bus address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid combinationally during a read of REG_ADDR |
| warn_sel_o | output | 1 | Warning trip-point select to the detector |
| detect_sel_o | output | 1 | Detect trip-point select to the detector |

## Verification
The bench targets the acknowledge race in the two cycles after the raw input falls, when the synchronizer still holds a 1. A design that cleared on acknowledge there, or that skipped the synchronizer, would read 0x10 instead of 0x90. It measures the synchronizer latency exactly: a flag one cycle early or late shows up as a wrong bit 7. It also fires the general reset with the selects set and the supply still low. A design that cleared the selects on every reset would lose bit 4, and one that set the flag straight from the raw level would show bit 7 too early.

// File: rtl/lvw_pkg.sv
package lvw_pkg;
  localparam int REG_W    = 8;
  localparam int FLAG_BIT = 7;
  localparam int ACK_BIT  = 6;
  localparam int DET_BIT  = 5;
  localparam int WARN_BIT = 4;
  localparam int RSV_MSB  = 3;
endpackage

// File: rtl/lvw_sync.sv
module lvw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[LAST-1:0], d_i};
  end

  assign q_o = shreg[LAST];
endmodule

// File: rtl/lvw_flag.sv
module lvw_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (ack_i) flag_o <= 1'b0;
  end

  // R3 / R5: an active condition always leaves the flag high
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R3: sticky without acknowledge
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !ack_i) |=> flag_o);
  // R4: acknowledge clears when the condition is gone
  p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !set_i) |=> !flag_o);
  // R3: the flag only rises from a set condition
  p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(set_i));
endmodule

// File: rtl/lvw_trip_sel.sv
module lvw_trip_sel (
  input  logic clk,
  input  logic por_n,
  input  logic load_i,
  input  logic det_d,
  input  logic warn_d,
  output logic det_o,
  output logic warn_o
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      det_o  <= 1'b0;
      warn_o <= 1'b0;
    end else if (load_i) begin
      det_o  <= det_d;
      warn_o <= warn_d;
    end
  end

  // R6: a load takes both select bits
  p_load_r6: assert property (@(posedge clk) disable iff (!por_n)
    load_i |=> (det_o == $past(det_d)) && (warn_o == $past(warn_d)));
  // R8: no load, no change
  p_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
    !load_i |=> $stable({det_o, warn_o}));
endmodule

// File: rtl/lvw_status_reg.sv
module lvw_status_reg
  import lvw_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h3C,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              below_warn_i,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              warn_sel_o,
  output logic              detect_sel_o
);
  logic any_rst_n;
  logic hit, wr_hit, rd_hit, ack;
  logic below_s, flag;
  logic unused_wbits;

  assign any_rst_n    = por_n & sys_rst_n;
  assign hit          = reg_en && (reg_addr == REG_ADDR);
  assign wr_hit       = hit && reg_wr;
  assign rd_hit       = hit && !reg_wr;
  assign ack          = wr_hit && reg_wdata[ACK_BIT];
  assign unused_wbits = ^{reg_wdata[FLAG_BIT], reg_wdata[RSV_MSB:0]};

  lvw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (any_rst_n),
    .d_i   (below_warn_i),
    .q_o   (below_s)
  );

  lvw_flag u_flag (
    .clk    (clk),
    .rst_n  (any_rst_n),
    .set_i  (below_s),
    .ack_i  (ack),
    .flag_o (flag)
  );

  lvw_trip_sel u_sel (
    .clk    (clk),
    .por_n  (por_n),
    .load_i (wr_hit),
    .det_d  (reg_wdata[DET_BIT]),
    .warn_d (reg_wdata[WARN_BIT]),
    .det_o  (detect_sel_o),
    .warn_o (warn_sel_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (rd_hit) begin
      reg_rdata[FLAG_BIT] = flag;
      reg_rdata[DET_BIT]  = detect_sel_o;
      reg_rdata[WARN_BIT] = warn_sel_o;
    end
  end

  // R8: bus cycles that miss the address leave the selects alone
  p_miss_keeps_sel_r8: assert property (@(posedge clk) disable iff (!por_n)
    !(reg_en && reg_wr && reg_addr == REG_ADDR) |=> $stable({detect_sel_o, warn_sel_o}));
  // R7: reserved and strobe positions never read as 1
  p_zero_bits_r7: assert property (@(posedge clk) disable iff (!por_n)
    (reg_rdata[ACK_BIT] == 1'b0) && (reg_rdata[RSV_MSB:0] == '0));
endmodule

// File: tb/lvw_status_reg_test.sv
module lvw_status_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ADDR = 8'h3C;

  logic clk = 0, por_n = 0, sys_rst_n = 0, below = 0;
  logic reg_en = 0, reg_wr = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic warn_sel, det_sel;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lvw_status_reg uut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .below_warn_i(below),
    .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .warn_sel_o(warn_sel), .detect_sel_o(det_sel)
  );

  // monitor: pops expected reads and compares
  initial forever begin
    @(negedge clk); #1;
    if (reg_en && !reg_wr && exp_q.size() > 0) begin
      logic [7:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      compared++;
      if (reg_rdata !== e) begin
        mismatched++;
        $display("FAIL %s: rdata=%02h expected=%02h", t, reg_rdata, e);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    reg_en = 1; reg_wr = 0; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_en = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_en = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_wr = 0;
  endtask

  task automatic chk_sel(input logic d, input logic w, input string t);
    #1;
    compared++;
    if (det_sel !== d || warn_sel !== w) begin
      mismatched++;
      $display("FAIL %s: det/warn=%b%b expected=%b%b", t, det_sel, warn_sel, d, w);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1; sys_rst_n = 1;
    chk_sel(0, 0, "R1 selects after power-on");
    rd(ADDR, 8'h00, "R1 read after power-on");

    wr(ADDR, 8'h30);
    chk_sel(1, 1, "R6 both selects high");
    rd(ADDR, 8'h30, "R6 readback 0x30");
    wr(ADDR, 8'hFF);
    rd(ADDR, 8'h30, "R7 bit7/bit6/bits3..0 ignored");
    wr(ADDR, 8'h10);
    chk_sel(0, 1, "R6 detect low warn high");
    rd(ADDR, 8'h10, "R6 readback 0x10");

    wr(8'h3D, 8'h20);
    rd(ADDR, 8'h10, "R8 write to other address ignored");
    rd(8'h3D, 8'h00, "R8 read of other address is zero");

    // synchronizer latency
    @(negedge clk); below = 1;
    repeat (2) @(posedge clk);
    rd(ADDR, 8'h10, "R3 flag not yet set after two edges");
    rd(ADDR, 8'h90, "R3 flag set after third edge");
    below = 0;
    repeat (5) @(negedge clk);
    rd(ADDR, 8'h90, "R3 flag sticky after input falls");

    // acknowledge while warning active
    below = 1;
    repeat (4) @(negedge clk);
    wr(ADDR, 8'h50);
    rd(ADDR, 8'h90, "R5 ack ignored while warning active");
    below = 0;
    wr(ADDR, 8'h50);
    rd(ADDR, 8'h90, "R5 ack ignored while synchronizer still high");
    repeat (3) @(negedge clk);
    wr(ADDR, 8'h50);
    rd(ADDR, 8'h10, "R4 ack clears flag");

    // general reset with supply still low
    below = 1;
    repeat (4) @(negedge clk);
    rd(ADDR, 8'h90, "R3 flag set before general reset");
    @(negedge clk); sys_rst_n = 0;
    repeat (2) @(negedge clk); sys_rst_n = 1;
    chk_sel(0, 1, "R2 selects survive general reset");
    rd(ADDR, 8'h10, "R2 flag cleared by general reset");
    rd(ADDR, 8'h90, "R9 flag from synchronized level after reset");

    // power-on reset
    below = 0;
    @(negedge clk); por_n = 0;
    repeat (2) @(negedge clk); por_n = 1;
    chk_sel(0, 0, "R1 selects cleared by power-on reset");
    rd(ADDR, 8'h00, "R1 register clear after power-on reset");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule